// File: doc/BRIEF.md
# Escalating Single-Cycle Clock Glitch Generator

The block divides a fast reference clock into a test clock whose nominal period is a fixed number of reference ticks. After a start request it alters exactly one test-clock cycle out of every `GLITCH_EVERY` cycles. In shorten mode that cycle loses a whole number of ticks. In stretch mode it gains them. The size of the change is the current step, counted in units of 10 percent of the nominal period.

A small sequencer holds each step for an observation window of glitch events. If no anomaly is reported during the window, it moves to the next step. The sequence ends in one of two ways. If an anomaly is reported, the step is frozen and flagged. If the deepest step completes cleanly, done is raised. In both end states the test clock falls back to its nominal shape.

The block is meant for margin testing of a target that runs on the test clock. The anomaly input comes from whatever logic watches that target.

Top module: `glitch_clock_margin`

## Requirements
- R1: Outside glitch cycles, every test-clock period is 10 reference ticks: 5 ticks high, then 5 ticks low.
- R2: While a sequence runs, exactly one test-clock cycle in every `GLITCH_EVERY` is altered. Consecutive altered cycles are `GLITCH_EVERY` rising edges apart.
- R3: Shorten mode (`lengthen_i`=0) at step k gives a period of 10-k ticks. Ticks are removed from the high phase first, so the high phase is max(1, 5-k) ticks. Stretch mode (`lengthen_i`=1) gives a period of 10+k ticks with a high phase of 5+k ticks. The mode is latched at start.
- R4: Steps are applied in the order 1, 2, 3, 4, 5. Each step is used for W glitch events, where W is `window_i` latched at start. A `window_i` of 0 is treated as 1.
- R5: The fifth step can complete its window with no anomaly. In that case `done_o` rises, `step_o` stays at 5, and no further cycle is altered.
- R6: `anomaly_i` may be high while a sequence runs. Then `found_o` rises, `step_o` holds the step in use at that moment, and no new altered cycle starts.
- R7: A `start_i` pulse while idle, done or found starts a new sequence. It clears `done_o` and `found_o` and sets `step_o` to 1. A `start_i` pulse while a sequence runs has no effect.
- R8: Synchronous reset sets `step_o` to 1 and clears `done_o` and `found_o`. It returns the test clock to its nominal shape, and no altered cycle appears until the next start.
- R9: `done_o` and `found_o` are never high together, and `step_o` always lies in 1..5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref_i | input | 1 | Fast reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request pulse |
| anomaly_i | input | 1 | Target misbehaviour seen |
| window_i | input | WIN_W | Glitch events per step (0 acts as 1) |
| lengthen_i | input | 1 | 1 = stretch mode, 0 = shorten mode |
| tclk_o | output | 1 | Test clock |
| step_o | output | SW | Current step, in 10 percent units |
| done_o | output | 1 | Deepest step finished cleanly |
| found_o | output | 1 | Anomaly reported, step frozen |

## Verification
The bench measures every test-clock period in reference ticks and logs each non-nominal one, so the check does not depend on internal latency. It targets several corner cases:

- **Step 5 shape.** This is the one step where the low phase must also lose a tick. A design that clipped only the high phase would produce a zero-width high or a wrong period there.
- **Window of zero.** A design that did not treat 0 as 1 would stall or wrap its event counter.
- **Anomaly on the last step.** A design that let done win over the anomaly would report the wrong flag.
- **Start or reset in the middle of a run.** A design that restarted on a start pulse mid-run would repeat steps. A design that kept glitching after reset would show altered periods with no start request.

// File: rtl/glitch_margin_pkg.sv
package glitch_margin_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_RUN   = 2'd1,
    SEQ_DONE  = 2'd2,
    SEQ_FOUND = 2'd3
  } seq_state_e;

endpackage

// File: rtl/glitch_shape.sv
// Converts a step number and a mode into the high and low tick counts
// of one altered test-clock cycle.
module glitch_shape #(
  parameter int NOM_TICKS  = 10,
  parameter int STEP_TICKS = 1,
  parameter int MAX_STEP   = 5,
  parameter int SW         = 3,
  parameter int CW         = 4
) (
  input  logic [SW-1:0] step_i,
  input  logic          lengthen_i,
  output logic [CW-1:0] hi_o,
  output logic [CW-1:0] lo_o
);

  localparam int HI_NOM = NOM_TICKS / 2;
  localparam int LO_NOM = NOM_TICKS - HI_NOM;

  int cut;
  int hi_i;
  int lo_i;

  always_comb begin
    cut = int'(step_i) * STEP_TICKS;
    if (lengthen_i) begin
      hi_i = HI_NOM + cut;
      lo_i = LO_NOM;
    end else if (cut < HI_NOM) begin
      hi_i = HI_NOM - cut;
      lo_i = LO_NOM;
    end else begin
      // High phase kept at one tick; the rest comes out of the low phase.
      hi_i = 1;
      lo_i = LO_NOM - (cut - (HI_NOM - 1));
    end
  end

  assign hi_o = CW'(hi_i);
  assign lo_o = CW'(lo_i);

endmodule

// File: rtl/glitch_phase_gen.sv
// Tick counter producing the test clock. Each cycle's shape is loaded at
// its first tick and stays fixed until the cycle ends.
module glitch_phase_gen #(
  parameter int NOM_TICKS = 10,
  parameter int CW        = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          glitch_next_i,
  input  logic [CW-1:0] g_hi_i,
  input  logic [CW-1:0] g_lo_i,
  output logic          tclk_o,
  output logic          seg_end_o,
  output logic          glitch_live_o
);

  localparam int HI_NOM = NOM_TICKS / 2;
  localparam int LO_NOM = NOM_TICKS - HI_NOM;

  logic [CW-1:0] ph, ph_n;
  logic [CW-1:0] cur_hi, cur_hi_n;
  logic [CW-1:0] cur_lo, cur_lo_n;
  logic [CW-1:0] last_ph;
  logic          live, live_n;
  logic          tclk_q;

  assign last_ph   = cur_hi + cur_lo - CW'(1);
  assign seg_end_o = (ph == last_ph);

  always_comb begin
    if (seg_end_o) begin
      ph_n     = '0;
      cur_hi_n = glitch_next_i ? g_hi_i : CW'(HI_NOM);
      cur_lo_n = glitch_next_i ? g_lo_i : CW'(LO_NOM);
      live_n   = glitch_next_i;
    end else begin
      ph_n     = ph + CW'(1);
      cur_hi_n = cur_hi;
      cur_lo_n = cur_lo;
      live_n   = live;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= CW'(NOM_TICKS - 1);
      cur_hi <= CW'(HI_NOM);
      cur_lo <= CW'(LO_NOM);
      live   <= 1'b0;
      tclk_q <= 1'b0;
    end else begin
      ph     <= ph_n;
      cur_hi <= cur_hi_n;
      cur_lo <= cur_lo_n;
      live   <= live_n;
      tclk_q <= (ph_n < cur_hi_n);
    end
  end

  assign tclk_o        = tclk_q;
  assign glitch_live_o = live;

endmodule

// File: rtl/glitch_sequencer.sv
// Counts test-clock cycles, picks the altered cycle and walks the step
// ladder one observation window at a time.
module glitch_sequencer
  import glitch_margin_pkg::*;
#(
  parameter int GLITCH_EVERY = 1000,
  parameter int MAX_STEP     = 5,
  parameter int WIN_W        = 8,
  parameter int SW           = 3,
  parameter int GW           = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             anomaly_i,
  input  logic [WIN_W-1:0] window_i,
  input  logic             lengthen_i,
  input  logic             seg_end_i,
  input  logic             glitch_end_i,
  output logic             glitch_next_o,
  output logic             lengthen_o,
  output logic [SW-1:0]    step_o,
  output logic             done_o,
  output logic             found_o
);

  seq_state_e       state;
  logic [GW-1:0]    cyc, cyc_next;
  logic [WIN_W-1:0] evt, win;
  logic [SW-1:0]    step;
  logic             len_q, done_q, found_q;

  assign cyc_next = (cyc == GW'(GLITCH_EVERY - 1)) ? '0 : cyc + GW'(1);

  assign glitch_next_o = (state == SEQ_RUN) && !anomaly_i &&
                         (cyc_next == GW'(GLITCH_EVERY - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SEQ_IDLE;
      cyc     <= '0;
      evt     <= '0;
      win     <= WIN_W'(1);
      step    <= SW'(1);
      len_q   <= 1'b0;
      done_q  <= 1'b0;
      found_q <= 1'b0;
    end else begin
      if (seg_end_i) cyc <= cyc_next;
      case (state)
        SEQ_RUN: begin
          if (anomaly_i) begin
            state   <= SEQ_FOUND;
            found_q <= 1'b1;
          end else if (glitch_end_i) begin
            if (evt == win - WIN_W'(1)) begin
              evt <= '0;
              if (step == SW'(MAX_STEP)) begin
                state  <= SEQ_DONE;
                done_q <= 1'b1;
              end else begin
                step <= step + SW'(1);
              end
            end else begin
              evt <= evt + WIN_W'(1);
            end
          end
        end
        default: begin
          if (start_i) begin
            state   <= SEQ_RUN;
            cyc     <= '0;
            evt     <= '0;
            win     <= (window_i == '0) ? WIN_W'(1) : window_i;
            step    <= SW'(1);
            len_q   <= lengthen_i;
            done_q  <= 1'b0;
            found_q <= 1'b0;
          end
        end
      endcase
    end
  end

  assign lengthen_o = len_q;
  assign step_o     = step;
  assign done_o     = done_q;
  assign found_o    = found_q;

endmodule

// File: rtl/glitch_clock_margin.sv
module glitch_clock_margin #(
  parameter int NOM_TICKS    = 10,
  parameter int GLITCH_EVERY = 1000,
  parameter int STEP_TICKS   = 1,
  parameter int MAX_STEP     = 5,
  parameter int WIN_W        = 8,
  localparam int SW = $clog2(MAX_STEP + 1),
  localparam int CW = $clog2(NOM_TICKS + MAX_STEP * STEP_TICKS + 1),
  localparam int GW = $clog2(GLITCH_EVERY)
) (
  input  logic             clk_ref_i,
  input  logic             rst_i,
  input  logic             start_i,
  input  logic             anomaly_i,
  input  logic [WIN_W-1:0] window_i,
  input  logic             lengthen_i,
  output logic             tclk_o,
  output logic [SW-1:0]    step_o,
  output logic             done_o,
  output logic             found_o
);

  logic          seg_end, glitch_live, glitch_next, len_mode;
  logic [CW-1:0] g_hi, g_lo;

  glitch_sequencer #(
    .GLITCH_EVERY(GLITCH_EVERY), .MAX_STEP(MAX_STEP),
    .WIN_W(WIN_W), .SW(SW), .GW(GW)
  ) u_seq (
    .clk          (clk_ref_i),
    .rst          (rst_i),
    .start_i      (start_i),
    .anomaly_i    (anomaly_i),
    .window_i     (window_i),
    .lengthen_i   (lengthen_i),
    .seg_end_i    (seg_end),
    .glitch_end_i (seg_end & glitch_live),
    .glitch_next_o(glitch_next),
    .lengthen_o   (len_mode),
    .step_o       (step_o),
    .done_o       (done_o),
    .found_o      (found_o)
  );

  glitch_shape #(
    .NOM_TICKS(NOM_TICKS), .STEP_TICKS(STEP_TICKS),
    .MAX_STEP(MAX_STEP), .SW(SW), .CW(CW)
  ) u_shape (
    .step_i    (step_o),
    .lengthen_i(len_mode),
    .hi_o      (g_hi),
    .lo_o      (g_lo)
  );

  glitch_phase_gen #(
    .NOM_TICKS(NOM_TICKS), .CW(CW)
  ) u_phase (
    .clk          (clk_ref_i),
    .rst          (rst_i),
    .glitch_next_i(glitch_next),
    .g_hi_i       (g_hi),
    .g_lo_i       (g_lo),
    .tclk_o       (tclk_o),
    .seg_end_o    (seg_end),
    .glitch_live_o(glitch_live)
  );

endmodule

// File: rtl/glitch_margin_chk.sv
module glitch_margin_chk #(
  parameter int GLITCH_EVERY = 1000,
  parameter int MAX_STEP     = 5,
  parameter int SW           = 3,
  parameter int GW           = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic          done_o,
  input logic          found_o,
  input logic [SW-1:0] step_o,
  input logic          seg_end,
  input logic          glitch_live
);

  logic [GW:0] gap;
  logic        seen;

  always_ff @(posedge clk) begin
    if (rst || start_i) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (seg_end) begin
      if (glitch_live) begin
        gap  <= '0;
        seen <= 1'b1;
      end else if (gap != {(GW+1){1'b1}}) begin
        gap <= gap + (GW+1)'(1);
      end
    end
  end

  // R2
  glitch_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (seg_end && glitch_live && seen && !start_i) |-> (gap == (GW+1)'(GLITCH_EVERY - 1)));

  // R9
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(done_o && found_o));

  // R9
  step_range_chk: assert property (@(posedge clk) disable iff (rst)
    (step_o >= SW'(1)) && (step_o <= SW'(MAX_STEP)));

  // R4
  step_order_chk: assert property (@(posedge clk) disable iff (rst)
    (step_o != $past(step_o)) |-> ((step_o == $past(step_o) + SW'(1)) || (step_o == SW'(1))));

  // R6
  found_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (found_o && !start_i) |=> (found_o && $stable(step_o)));

  // R5
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !glitch_live);

endmodule

bind glitch_clock_margin glitch_margin_chk #(
  .GLITCH_EVERY(GLITCH_EVERY), .MAX_STEP(MAX_STEP), .SW(SW), .GW(GW)
) u_chk (
  .clk        (clk_ref_i),
  .rst        (rst_i),
  .start_i    (start_i),
  .done_o     (done_o),
  .found_o    (found_o),
  .step_o     (step_o),
  .seg_end    (seg_end),
  .glitch_live(glitch_live)
);

// File: tb/test_glitch_clock_margin.sv
module test_glitch_clock_margin;

  localparam int G = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       anomaly = 1'b0;
  logic [7:0] window = 8'd1;
  logic       lengthen = 1'b0;
  logic       tclk;
  logic [2:0] step;
  logic       done, found;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  glitch_clock_margin #(.GLITCH_EVERY(G)) i_glitch_clock_margin (
    .clk_ref_i(clk), .rst_i(rst), .start_i(start), .anomaly_i(anomaly),
    .window_i(window), .lengthen_i(lengthen), .tclk_o(tclk),
    .step_o(step), .done_o(done), .found_o(found)
  );

  // Period monitor: logs every non-nominal test-clock period.
  int   edges = 0, lg_n = 0, hi_c = 0, lo_c = 0, last_per = 0, last_hi = 0;
  int   lg_per[128], lg_hi[128], lg_edge[128];
  bit   seen = 0;
  logic prev = 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      seen = 0; hi_c = 0; lo_c = 0;
    end else begin
      if (tclk && !prev) begin
        if (seen) begin
          last_per = hi_c + lo_c;
          last_hi  = hi_c;
          if (!(last_per == 10 && last_hi == 5)) begin
            if (lg_n < 128) begin
              lg_per[lg_n] = last_per; lg_hi[lg_n] = last_hi; lg_edge[lg_n] = edges;
            end
            lg_n++;
          end
        end
        edges++; hi_c = 0; lo_c = 0; seen = 1;
      end
      if (tclk) hi_c++; else lo_c++;
    end
    prev = tclk;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // {lengthen, window[3:0], target[2:0], exp_step[2:0], exp_done, exp_found}
  localparam logic [12:0] VEC [7] = '{
    {1'b0, 4'd1, 3'd0, 3'd5, 1'b1, 1'b0},
    {1'b0, 4'd2, 3'd0, 3'd5, 1'b1, 1'b0},
    {1'b1, 4'd1, 3'd0, 3'd5, 1'b1, 1'b0},
    {1'b0, 4'd2, 3'd3, 3'd3, 1'b0, 1'b1},
    {1'b1, 4'd3, 3'd1, 3'd1, 1'b0, 1'b1},
    {1'b0, 4'd0, 3'd0, 3'd5, 1'b1, 1'b0},
    {1'b0, 4'd2, 3'd5, 3'd5, 1'b0, 1'b1}
  };

  function automatic int exp_per(input bit lm, input int k);
    return lm ? 10 + k : 10 - k;
  endfunction

  function automatic int exp_hi(input bit lm, input int k);
    if (lm) return 5 + k;
    return (5 - k > 1) ? 5 - k : 1;
  endfunction

  task automatic run_vec(input int v);
    bit lm      = VEC[v][12];
    int w       = int'(VEC[v][11:8]);
    int tgt     = int'(VEC[v][7:5]);
    int weff    = (w == 0) ? 1 : w;
    int exp_n   = (tgt == 0) ? 5 * weff : (tgt - 1) * weff + 1;
    int base    = lg_n;
    bit injected = 0;
    bit restarted = 0;
    int guard   = 0;
    lengthen = lm; window = 8'(w);
    start = 1'b1; @(negedge clk); start = 1'b0;
    // R7: fresh sequence right after start
    check(step == 3'd1 && !done && !found, "R7 start clears", {29'd0, step}, 1);
    while (!(done || found) && guard < 20000) begin
      @(negedge clk);
      anomaly = 1'b0;
      guard++;
      if (tgt != 0 && !injected && lg_n > base &&
          lg_per[lg_n-1] == exp_per(lm, tgt)) begin
        anomaly = 1'b1; injected = 1;
      end
      // R7: start while running is ignored (the logged sequence must not repeat)
      if (v == 1 && !restarted && lg_n - base == 3) begin
        start = 1'b1; @(negedge clk); start = 1'b0; restarted = 1;
      end
    end
    anomaly = 1'b0;
    ticks(3 * G * 10);
    // R5 R6: final flags and latched step
    check(step == VEC[v][4:2], "R5/R6 final step", int'(step), int'(VEC[v][4:2]));
    check(done == VEC[v][1], "R5 done flag", int'(done), int'(VEC[v][1]));
    check(found == VEC[v][0], "R6 found flag", int'(found), int'(VEC[v][0]));
    // R4 R5 R6: number of altered cycles, none after the end
    check(lg_n - base == exp_n, "R4 glitch count", lg_n - base, exp_n);
    for (int i = 0; i < exp_n && base + i < lg_n; i++) begin
      int k = i / weff + 1;
      // R3: altered period and high phase at step k
      check(lg_per[base+i] == exp_per(lm, k) && lg_hi[base+i] == exp_hi(lm, k),
            "R3 glitch shape", lg_per[base+i] * 100 + lg_hi[base+i],
            exp_per(lm, k) * 100 + exp_hi(lm, k));
      if (i > 0)
        // R2: one altered cycle every G cycles
        check(lg_edge[base+i] - lg_edge[base+i-1] == G, "R2 spacing",
              lg_edge[base+i] - lg_edge[base+i-1], G);
    end
  endtask

  initial begin
    int base;
    ticks(4);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    check(step == 3'd1, "R8 reset step", int'(step), 1);
    check(!done && !found, "R8 reset flags", int'({done, found}), 0);
    ticks(30 * 10);
    // R1: nominal period, no glitches before start
    check(last_per == 10 && last_hi == 5, "R1 nominal shape", last_per * 100 + last_hi, 1005);
    check(lg_n == 0, "R8 no glitch before start", lg_n, 0);

    for (int v = 0; v < 7; v++) run_vec(v);

    // R8: reset in the middle of a run
    lengthen = 1'b0; window = 8'd1;
    start = 1'b1; @(negedge clk); start = 1'b0;
    base = lg_n;
    while (lg_n < base + 2) @(negedge clk);
    rst = 1'b1; ticks(3); rst = 1'b0;
    @(negedge clk);
    check(step == 3'd1 && !done && !found, "R8 mid-run reset", int'(step), 1);
    base = lg_n;
    ticks(3 * G * 10);
    check(lg_n == base, "R8 no glitch after reset", lg_n - base, 0);
    check(last_per == 10 && last_hi == 5, "R1 nominal after reset", last_per * 100 + last_hi, 1005);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    ticks(150000);
    checks++; failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule